// File: doc/BRIEF.md
# Multi-Entry Glitch Burst Sequencer

The sequencer turns one trigger event into a train of fault-injection glitch bursts. A table of up to 32 entries holds, for each burst, a wait length in clock cycles and a burst length in cycles. Once a rising trigger edge is accepted, the block walks the table: it waits out the entry's offset, opens a glitch window for the entry's repeat count of consecutive cycles, then moves on to the next entry. The last entry used is set by an entry-count input that is captured at the trigger.

The shape of each glitch within a cycle (its width and phase) comes from a fast clock outside this block. It arrives here as a single pulse-enable input. All entries share it. Four output modes combine the glitch window and that pulse with the target clock: exclusive-or, or, the glitch alone, or the raw window held high for whole cycles. The table is loaded through a simple write port. A busy flag and a done flag report the progress of the sequence.

Top module: `glitch_seq`

## Requirements
- R1: A sequence starts only at a clock edge where `trig_in` is 1 and was 0 at the previous edge, and only while the block is idle. `busy` is 1 after that edge (edge E0). `done` is cleared at E0.
- R2: For entry 0, with offset O and repeat R, `glitch_window` is 1 after edges E0+O+1 through E0+O+R and is 0 after edges E0 through E0+O.
- R3: Each later entry i spends O_i+1 cycles with `glitch_window` at 0 after the previous entry's last cycle. Its window of R_i cycles follows at once.
- R4: An entry with repeat 0 produces no window cycles. It occupies only its O+1 wait cycles, and sequencing continues with the next entry.
- R5: The number of entries walked is `num_entries`, captured at E0, in the range 1 to 32. A value of 0 is treated as 1.
- R6: At the edge that ends the last entry, `busy` falls and `done` rises. `done` stays 1 until the next accepted trigger.
- R7: Rising trigger edges while busy have no effect on the sequence. A trigger still held high after completion does not start a new sequence.
- R8: `mode` encodings: 0 gives `tgt_clk ^ (glitch_window & phase_pulse)`; 1 gives `tgt_clk | (glitch_window & phase_pulse)`; 2 gives `glitch_window & phase_pulse`; 3 gives `glitch_window`. The output is combinational.
- R9: When `cfg_we` is 1 at a clock edge, `cfg_offset` and `cfg_repeat` are stored in entry `cfg_idx`. Later sequences use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger input, armed on rising edge |
| num_entries | input | 6 | Count of table entries to walk (1..32) |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 5 | Table entry to write |
| cfg_offset | input | 32 | Wait cycles before the entry's burst |
| cfg_repeat | input | 14 | Burst length in cycles (0..8192) |
| mode | input | 2 | Output combining mode |
| tgt_clk | input | 1 | Target clock level to combine |
| phase_pulse | input | 1 | Shared fast-clock glitch pulse enable |
| glitch_out | output | 1 | Combined glitch output |
| glitch_window | output | 1 | High during burst cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |

## Verification
A wrong counter or entry index inside the block shows up as a glitch window that lands on the wrong cycle or has the wrong length. The bench compares `glitch_window`, `busy` and `done` cycle by cycle against a trace it builds itself from the programmed table, so such an error appears within one cycle of its effect. A mishandled skip entry, entry-count clamp or retrigger makes the whole trace shift or end early, which the same per-cycle comparison reports. The combining modes are checked on every input combination, both inside and outside a window.

// File: rtl/glseq_pkg.sv
package glseq_pkg;

    typedef enum logic [1:0] {
        MODE_XOR    = 2'd0,
        MODE_OR     = 2'd1,
        MODE_GLITCH = 2'd2,
        MODE_ENABLE = 2'd3
    } glitch_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } seq_state_e;

    localparam int DEF_ENTRIES = 32;
    localparam int DEF_OFF_W   = 32;
    localparam int DEF_REP_W   = 14;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/glseq_edge.sv
module glseq_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_i;
    end

    assign rise_o = trig_i & ~trig_q;

    // R1: a rise can only be reported when the previous sample was low
    a_r1_rise_needs_low: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/glseq_table.sv
module glseq_table #(
    parameter int ENTRIES = 32,
    parameter int OFF_W   = 32,
    parameter int REP_W   = 14,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [OFF_W-1:0] woff_i,
    input  logic [REP_W-1:0] wrep_i,
    input  logic [IDX_W-1:0] cur_idx_i,
    output logic [REP_W-1:0] cur_rep_o,
    input  logic [IDX_W-1:0] nxt_idx_i,
    output logic [OFF_W-1:0] nxt_off_o
);
    logic [OFF_W-1:0] off_mem [ENTRIES];
    logic [REP_W-1:0] rep_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we_i) begin
            off_mem[widx_i] <= woff_i;
            rep_mem[widx_i] <= wrep_i;
        end
    end

    assign cur_rep_o = rep_mem[cur_idx_i];
    assign nxt_off_o = off_mem[nxt_idx_i];
endmodule

// File: rtl/glseq_ctrl.sv
module glseq_ctrl
    import glseq_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int OFF_W   = 32,
    parameter int REP_W   = 14,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NUM_W  = $clog2(ENTRIES + 1),
    localparam int CNT_W  = max_int(OFF_W, REP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [REP_W-1:0] cur_rep_i,
    input  logic [OFF_W-1:0] nxt_off_i,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic [IDX_W-1:0] nxt_idx_o,
    output logic             window_o,
    output logic             busy_o,
    output logic             done_o
);
    seq_state_e       state;
    logic [IDX_W-1:0] idx, last;
    logic [CNT_W-1:0] cnt;
    logic             done_q;
    logic [IDX_W-1:0] last_in;

    always_comb begin
        if (num_i == '0)
            last_in = '0;
        else if (num_i > NUM_W'(ENTRIES))
            last_in = IDX_W'(ENTRIES - 1);
        else
            last_in = IDX_W'(num_i - 1'b1);
    end

    assign nxt_idx_o = (state == ST_IDLE) ? '0 : IDX_W'(idx + 1'b1);
    assign cur_idx_o = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            last   <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (rise_i) begin
                    state  <= ST_WAIT;
                    idx    <= '0;
                    last   <= last_in;
                    cnt    <= CNT_W'(nxt_off_i);
                    done_q <= 1'b0;
                end
                ST_WAIT, ST_BURST: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (state == ST_WAIT && cur_rep_i != '0) begin
                        state <= ST_BURST;
                        cnt   <= CNT_W'(cur_rep_i) - 1'b1;
                    end else if (idx == last) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_WAIT;
                        idx   <= IDX_W'(idx + 1'b1);
                        cnt   <= CNT_W'(nxt_off_i);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign window_o = (state == ST_BURST);
    assign busy_o   = (state != ST_IDLE);
    assign done_o   = done_q;

    // R1: an accepted rising edge starts a sequence
    a_r1_arm: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && rise_i) |=> (busy_o && !done_o));
    // R2: a burst counts down one cycle at a time
    a_r2_burst_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BURST && cnt != '0) |=> (state == ST_BURST && cnt == $past(cnt) - 1'b1));
    // R3: glitch window only exists inside a running sequence
    a_r3_window_busy: assert property (@(posedge clk) disable iff (rst)
        window_o |-> busy_o);
    // R5: entry index never passes the captured last entry
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (idx <= last));
    // R6: done and busy are never high together
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    // R7: while busy, the captured last entry does not change
    a_r7_hold_last: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(last));
endmodule

// File: rtl/glseq_outmux.sv
module glseq_outmux
    import glseq_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       window_i,
    input  logic       pulse_i,
    input  logic       tgt_clk_i,
    output logic       out_o
);
    logic glitch;
    assign glitch = window_i & pulse_i;

    always_comb begin
        case (glitch_mode_e'(mode_i))
            MODE_XOR:    out_o = tgt_clk_i ^ glitch;
            MODE_OR:     out_o = tgt_clk_i | glitch;
            MODE_GLITCH: out_o = glitch;
            default:     out_o = window_i;
        endcase
    end

    // R8: outside a window the glitch-only mode stays quiet
    always_comb begin
        if (!window_i && mode_i == 2'd2)
            a_r8_quiet: assert (out_o == 1'b0);
    end
endmodule

// File: rtl/glitch_seq.sv
module glitch_seq
    import glseq_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int OFF_W   = DEF_OFF_W,
    parameter int REP_W   = DEF_REP_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NUM_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic [NUM_W-1:0] num_entries,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic [REP_W-1:0] cfg_repeat,
    input  logic [1:0]       mode,
    input  logic             tgt_clk,
    input  logic             phase_pulse,
    output logic             glitch_out,
    output logic             glitch_window,
    output logic             busy,
    output logic             done
);
    logic             rise;
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic [REP_W-1:0] cur_rep;
    logic [OFF_W-1:0] nxt_off;

    glseq_edge u_edge (
        .clk(clk), .rst(rst), .trig_i(trig_in), .rise_o(rise)
    );

    glseq_table #(.ENTRIES(ENTRIES), .OFF_W(OFF_W), .REP_W(REP_W)) u_table (
        .clk(clk), .we_i(cfg_we), .widx_i(cfg_idx), .woff_i(cfg_offset),
        .wrep_i(cfg_repeat), .cur_idx_i(cur_idx), .cur_rep_o(cur_rep),
        .nxt_idx_i(nxt_idx), .nxt_off_o(nxt_off)
    );

    glseq_ctrl #(.ENTRIES(ENTRIES), .OFF_W(OFF_W), .REP_W(REP_W)) u_ctrl (
        .clk(clk), .rst(rst), .rise_i(rise), .num_i(num_entries),
        .cur_rep_i(cur_rep), .nxt_off_i(nxt_off), .cur_idx_o(cur_idx),
        .nxt_idx_o(nxt_idx), .window_o(glitch_window), .busy_o(busy),
        .done_o(done)
    );

    glseq_outmux u_outmux (
        .mode_i(mode), .window_i(glitch_window), .pulse_i(phase_pulse),
        .tgt_clk_i(tgt_clk), .out_o(glitch_out)
    );
endmodule

// File: tb/glitch_seq_bench.sv
module glitch_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        trig_in;
    logic [5:0]  num_entries;
    logic        cfg_we;
    logic [4:0]  cfg_idx;
    logic [31:0] cfg_offset;
    logic [13:0] cfg_repeat;
    logic [1:0]  mode;
    logic        tgt_clk;
    logic        phase_pulse;
    logic        glitch_out, glitch_window, busy, done;

    int checks = 0;
    int errors = 0;

    int m_off [32];
    int m_rep [32];
    bit exp_win [2048];

    always #2 clk = ~clk;

    glitch_seq u_glitch_seq (
        .clk(clk), .rst(rst), .trig_in(trig_in), .num_entries(num_entries),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_offset(cfg_offset),
        .cfg_repeat(cfg_repeat), .mode(mode), .tgt_clk(tgt_clk),
        .phase_pulse(phase_pulse), .glitch_out(glitch_out),
        .glitch_window(glitch_window), .busy(busy), .done(done)
    );

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R9: program one table entry
    task automatic put_entry(input int i, input int off, input int rep);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'(i); cfg_offset = 32'(off); cfg_repeat = 14'(rep);
        m_off[i] = off; m_rep[i] = rep;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Build expected trace and run one sequence; returns via checks
    task automatic run_seq(input int n, input bit poke, input string req);
        int used, p, bad, bj, ba, be;
        used = (n == 0) ? 1 : n;
        p = 0;
        for (int k = 0; k < 2048; k++) exp_win[k] = 1'b0;
        for (int i = 0; i < used; i++) begin
            for (int k = 1; k <= m_rep[i]; k++) exp_win[p + m_off[i] + k] = 1'b1;
            p = p + m_off[i] + m_rep[i] + 1;
        end
        num_entries = 6'(n);
        bad = 0; bj = 0; ba = 0; be = 0;
        @(negedge clk);
        trig_in = 1'b1;
        for (int j = 0; j < p + 3; j++) begin
            @(negedge clk);
            if (poke && j == 2) trig_in = 1'b0;
            if (poke && j == 4) trig_in = 1'b1;
            if (poke && j == 5) num_entries = 6'd1;
            if (bad == 0) begin
                if (glitch_window !== exp_win[j]) begin
                    bad = 1; bj = j; ba = int'(glitch_window); be = int'(exp_win[j]);
                end else if (busy !== (j < p)) begin
                    bad = 2; bj = j; ba = int'(busy); be = int'(j < p);
                end else if (done !== (j >= p)) begin
                    bad = 3; bj = j; ba = int'(done); be = int'(j >= p);
                end
            end
        end
        if (bad != 0)
            $display("  trace mismatch at cycle %0d (signal %0d)", bj, bad);
        check(bad == 0, req, ba, be);
        // R7: trigger still held high must not restart
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == 1'b1, "R7 held trigger no restart", int'(busy), 0);
        trig_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; trig_in = 1'b0; num_entries = 6'd1; cfg_we = 1'b0;
        cfg_idx = '0; cfg_offset = '0; cfg_repeat = '0; mode = 2'd0;
        tgt_clk = 1'b0; phase_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "reset busy", int'(busy), 0);
        check(done == 1'b0, "reset done", int'(done), 0);
        check(glitch_window == 1'b0, "reset window", int'(glitch_window), 0);
        check(glitch_out == 1'b0, "reset out", int'(glitch_out), 0);
    endtask

    task automatic t_single;
        put_entry(0, 3, 4);
        run_seq(1, 1'b0, "R1 R2 R6 single entry trace");
    endtask

    task automatic t_multi;
        put_entry(0, 2, 3);
        put_entry(1, 0, 2);
        put_entry(2, 5, 1);
        run_seq(3, 1'b0, "R3 three entry trace");
    endtask

    task automatic t_skip;
        put_entry(0, 1, 2);
        put_entry(1, 4, 0);
        put_entry(2, 0, 3);
        run_seq(3, 1'b0, "R4 zero repeat skip trace");
        put_entry(0, 0, 0);
        run_seq(1, 1'b0, "R4 only entry skipped");
    endtask

    task automatic t_count;
        for (int i = 0; i < 32; i++) put_entry(i, i % 3, 1 + (i % 2));
        run_seq(32, 1'b0, "R5 thirty-two entries");
        run_seq(0, 1'b0, "R5 zero count acts as one");
        run_seq(2, 1'b1, "R5 R7 count latched, retrigger ignored");
    endtask

    task automatic t_rewrite;
        put_entry(0, 7, 2);
        run_seq(1, 1'b0, "R9 rewritten entry used");
    endtask

    task automatic t_modes;
        int e;
        // outside a window
        for (int md = 0; md < 4; md++)
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                mode = 2'(md); tgt_clk = c[0]; phase_pulse = c[1];
                #1;
                e = (md == 0 || md == 1) ? c[0] : 0;
                check(glitch_out == e[0], "R8 mode outside window", int'(glitch_out), e);
            end
        put_entry(0, 1, 60);
        num_entries = 6'd1;
        @(negedge clk); trig_in = 1'b1;
        repeat (3) @(negedge clk);
        check(glitch_window == 1'b1, "R8 window open", int'(glitch_window), 1);
        for (int md = 0; md < 4; md++)
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                mode = 2'(md); tgt_clk = c[0]; phase_pulse = c[1];
                #1;
                case (md)
                    0: e = c[0] ^ c[1];
                    1: e = c[0] | c[1];
                    2: e = c[1];
                    default: e = 1;
                endcase
                check(glitch_out == e[0], "R8 mode inside window", int'(glitch_out), e);
            end
        trig_in = 1'b0; mode = 2'd0; tgt_clk = 1'b0; phase_pulse = 1'b0;
        repeat (70) @(negedge clk);
        check(busy == 1'b0, "R6 long burst ends", int'(busy), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_skip();
        t_count();
        t_rewrite();
        t_modes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule